// File: doc/BRIEF.md
# Programmable AND-OR logic array

A small field-programmable sum-of-products block. Three data inputs feed an AND plane of four product terms. Each term is the AND of any chosen set of true and complemented input literals, and it does not have to be a full minterm. An OR plane then lets each of the three outputs sum any chosen set of those terms. A single term may feed several outputs, so the total number of terms, not the number of minterms, limits which functions the array can hold. A function set that needs more than four distinct products cannot be programmed. Minimisation into shared terms is done offline.

The pattern is held in 40 configuration flops. These are loaded through a serial port with an enable, a data bit and a done flag. The data path from `in_i` to `out_o` is purely combinational. The bit that leaves the far end of the shift chain is visible on `cfg_dout_o`, so loading a new pattern reads back the old one. The outputs are held at zero until a complete pattern has been loaded.

Top module: `pla_array`

## Requirements
- R1: After reset `cfg_done_o`, `cfg_dout_o` and `out_o` are all 0.
- R2: Each clock with `cfg_en_i` high shifts `cfg_data_i` into the pattern. The first bit sent ends up as the most significant stored bit. `cfg_done_o` goes high after exactly 40 such bits, and not after 39.
- R3: While `cfg_done_o` is low, `out_o` is 0 for every input value.
- R4: The stream position p (0 = first bit sent) is laid out as follows. For term t (0..3) and input j (2..0), position 6t+2(2-j) is the true-literal select and the next position is the complemented-literal select. Position 24+t is the enable of term t. Position 28+4k+t selects term t into output k (0..2). Input 2 (`in_i[2]`) is the most significant input.
- R5: A true-literal select requires its input to be 1, and a complemented-literal select requires it to be 0. An input with neither select set is ignored by the term. A term with both selects set for the same input is always 0.
- R6: A term whose enable bit is 0 is always 0. An enabled term with no literal selected is always 1.
- R7: Each output is the OR of its selected terms, and is 0 when no term is selected. One term may drive several outputs at once.
- R8: The shared-term pattern {xy'z', xy, x'z, x'yz'}, with x = `in_i[2]`, realises three functions over the input index `in_i`. `out_o[2]` is 1 for indices 1, 2, 3 and 4. `out_o[1]` is 1 for indices 2, 6 and 7. `out_o[0]` is 1 for indices 4, 6 and 7.
- R9: `cfg_dout_o` shows the most significant stored bit. Loading a new pattern therefore returns the previous pattern in the order it was originally sent.
- R10: The first shifted bit of a reload clears `cfg_done_o`. With `cfg_en_i` low, the pattern and `cfg_done_o` hold, whatever `cfg_data_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration flops |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Shift one configuration bit this cycle |
| cfg_data_i | input | 1 | Serial configuration bit |
| cfg_done_o | output | 1 | A full 40-bit pattern is loaded |
| cfg_dout_o | output | 1 | Readback: most significant stored bit |
| in_i | input | 3 | Logic inputs, bit 2 is x |
| out_o | output | 3 | Sum-of-products outputs |

## Verification
The assertions assume that `cfg_en_i` and `cfg_data_i` change only away from the rising edge. They also assume that `in_i` is ignored until done is high, because the outputs are gated rather than `in_i` being restricted. The stimulus drives every input on the falling edge and sweeps `in_i` only once a pattern is complete. Patterns are sent as complete 40-bit streams, apart from one deliberate 39-bit stop, so the done flag passes through every count. Expected outputs are computed from the stream layout of R4 with a separate term-by-term model. The shared-term pattern is also checked against its minterm lists.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned N_IN_DEF   = 3;
  localparam int unsigned N_TERM_DEF = 4;
  localparam int unsigned N_OUT_DEF  = 3;

  function automatic int unsigned cfg_width(int unsigned n_in, int unsigned n_term,
                                            int unsigned n_out);
    return n_term * 2 * n_in + n_term + n_out * n_term;
  endfunction
endpackage

// File: rtl/pla_cfg_shift.sv
module pla_cfg_shift #(
  parameter int unsigned W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         data_i,
  output logic [W-1:0] cfg_o,
  output logic         done_o,
  output logic         dout_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0]     cfg_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      cfg_q <= {cfg_q[W-2:0], data_i};
      // restart count on first bit of a reload
      cnt_q <= (cnt_q == FULL) ? CNT_W'(1) : cnt_q + 1'b1;
    end
  end

  assign cfg_o  = cfg_q;
  assign done_o = (cnt_q == FULL);
  assign dout_o = cfg_q[W-1];
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned N_TERM = 4
) (
  input  logic [N_IN-1:0]              in_i,
  input  logic [N_TERM-1:0][N_IN-1:0]  lit_t_i,
  input  logic [N_TERM-1:0][N_IN-1:0]  lit_c_i,
  input  logic [N_TERM-1:0]            term_en_i,
  output logic [N_TERM-1:0]            term_o
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] lit_ok;
    assign lit_ok    = (~lit_t_i[t] | in_i) & (~lit_c_i[t] | ~in_i);
    assign term_o[t] = term_en_i[t] & (&lit_ok);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 4,
  parameter int unsigned N_OUT  = 3
) (
  input  logic [N_TERM-1:0]             term_i,
  input  logic [N_OUT-1:0][N_TERM-1:0]  sel_i,
  output logic [N_OUT-1:0]              sum_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign sum_o[k] = |(sel_i[k] & term_i);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned N_IN   = N_IN_DEF,
  parameter int unsigned N_TERM = N_TERM_DEF,
  parameter int unsigned N_OUT  = N_OUT_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_data_i,
  output logic             cfg_done_o,
  output logic             cfg_dout_o,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o
);
  localparam int unsigned CFG_W = cfg_width(N_IN, N_TERM, N_OUT);
  localparam int unsigned AND_W = N_TERM * 2 * N_IN;
  localparam int unsigned EN_P  = AND_W;
  localparam int unsigned OR_P  = AND_W + N_TERM;

  logic [CFG_W-1:0]             cfg_q;
  logic [N_TERM-1:0][N_IN-1:0]  lit_t, lit_c;
  logic [N_TERM-1:0]            term_en, term;
  logic [N_OUT-1:0][N_TERM-1:0] or_sel;
  logic [N_OUT-1:0]             sum;

  pla_cfg_shift #(.W(CFG_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_en_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg_q),
    .done_o (cfg_done_o),
    .dout_o (cfg_dout_o)
  );

  // stream position p lives at cfg_q[CFG_W-1-p]
  for (genvar t = 0; t < N_TERM; t++) begin : g_fld_t
    for (genvar j = 0; j < N_IN; j++) begin : g_fld_j
      localparam int unsigned P = t * 2 * N_IN + 2 * (N_IN - 1 - j);
      assign lit_t[t][j] = cfg_q[CFG_W-1-P];
      assign lit_c[t][j] = cfg_q[CFG_W-2-P];
    end
    assign term_en[t] = cfg_q[CFG_W-1-(EN_P+t)];
    for (genvar k = 0; k < N_OUT; k++) begin : g_fld_k
      assign or_sel[k][t] = cfg_q[CFG_W-1-(OR_P+k*N_TERM+t)];
    end
  end

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_i      (in_i),
    .lit_t_i   (lit_t),
    .lit_c_i   (lit_c),
    .term_en_i (term_en),
    .term_o    (term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_i (term),
    .sel_i  (or_sel),
    .sum_o  (sum)
  );

  assign out_o = cfg_done_o ? sum : '0;
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned N_OUT = 3,
  parameter int unsigned CFG_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             cfg_data_i,
  input logic             cfg_done_o,
  input logic             cfg_dout_o,
  input logic [N_IN-1:0]  in_i,
  input logic [N_OUT-1:0] out_o,
  input logic [CFG_W-1:0] cfg_q
);
  p_out_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_o |-> out_o == '0);

  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_q[0] == $past(cfg_data_i));

  p_done_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_done_o) |-> $past(cfg_en_i));

  p_done_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i && cfg_done_o |=> !cfg_done_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_q) && $stable(cfg_done_o));

  p_readback_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_dout_o == $past(cfg_q[CFG_W-2]));

  p_out_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o && $stable(in_i) && $stable(cfg_q) |-> $stable(out_o));
endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .CFG_W(CFG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_en_i   (cfg_en_i),
  .cfg_data_i (cfg_data_i),
  .cfg_done_o (cfg_done_o),
  .cfg_dout_o (cfg_dout_o),
  .in_i       (in_i),
  .out_o      (out_o),
  .cfg_q      (cfg_q)
);

// File: tb/pla_array_tb.sv
`timescale 1ns/1ps
module pla_array_tb;
  localparam int W = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_en_i = 1'b0;
  logic       cfg_data_i = 1'b0;
  logic       cfg_done_o, cfg_dout_o;
  logic [2:0] in_i = 3'd0;
  logic [2:0] out_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  pla_array u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_data_i(cfg_data_i),
    .cfg_done_o(cfg_done_o), .cfg_dout_o(cfg_dout_o), .in_i(in_i), .out_o(out_o)
  );

  // st[p] = stream bit p, p = 0 sent first (R4 layout)
  typedef logic [W-1:0] stream_t;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void set_lit(ref stream_t s, input int t, input int j, input bit comp);
    s[6*t + 2*(2-j) + (comp ? 1 : 0)] = 1'b1;
  endfunction

  function automatic logic [2:0] model(input stream_t s, input logic [2:0] x);
    logic [3:0] term;
    logic [2:0] o;
    for (int t = 0; t < 4; t++) begin
      term[t] = s[24+t];
      for (int j = 0; j < 3; j++) begin
        if (s[6*t + 2*(2-j)] && !x[j]) term[t] = 1'b0;
        if (s[6*t + 2*(2-j) + 1] && x[j]) term[t] = 1'b0;
      end
    end
    o = '0;
    for (int k = 0; k < 3; k++)
      for (int t = 0; t < 4; t++)
        if (s[28 + 4*k + t] && term[t]) o[k] = 1'b1;
    return o;
  endfunction

  task automatic shift_bits(input stream_t s, input int n, output stream_t rb);
    rb = '0;
    for (int p = 0; p < n; p++) begin
      @(negedge clk_i);
      cfg_en_i   = 1'b1;
      cfg_data_i = s[p];
      #1 rb[p] = cfg_dout_o;
      @(posedge clk_i);
    end
    @(negedge clk_i);
    cfg_en_i = 1'b0;
    cfg_data_i = 1'b0;
  endtask

  task automatic sweep(input stream_t s, input string req);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk_i);
      in_i = 3'(v);
      #1 check(req, out_o, model(s, 3'(v)));
    end
  endtask

  stream_t ref_s, b_s, cur_s, rb;
  logic [15:0] lfsr;

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reference: t0=xy'z' t1=xy t2=x'z t3=x'yz'
    ref_s = '0;
    set_lit(ref_s, 0, 2, 0); set_lit(ref_s, 0, 1, 1); set_lit(ref_s, 0, 0, 1);
    set_lit(ref_s, 1, 2, 0); set_lit(ref_s, 1, 1, 0);
    set_lit(ref_s, 2, 2, 1); set_lit(ref_s, 2, 0, 0);
    set_lit(ref_s, 3, 2, 1); set_lit(ref_s, 3, 1, 0); set_lit(ref_s, 3, 0, 1);
    for (int t = 0; t < 4; t++) ref_s[24+t] = 1'b1;
    ref_s[28+0] = 1; ref_s[28+1] = 1;                       // out0 = t0|t1
    ref_s[32+3] = 1; ref_s[32+1] = 1;                       // out1 = t3|t1 (shared t1)
    ref_s[36+0] = 1; ref_s[36+2] = 1; ref_s[36+3] = 1;      // out2 = t0|t2|t3

    repeat (3) @(negedge clk_i);
    check("R1 done", cfg_done_o, 0);
    check("R1 dout", cfg_dout_o, 0);
    check("R1 out", out_o, 0);
    rst_ni = 1'b1;

    // R2/R3: stop after 39 bits
    in_i = 3'd1;
    shift_bits(ref_s, 39, rb);
    #1 check("R2 done after 39", cfg_done_o, 0);
    check("R3 out gated", out_o, 0);
    // restart a clean load: 1 more bit completes 40, then reload fully
    shift_bits(ref_s, 1, rb);
    #1 check("R2 done after 40", cfg_done_o, 1);
    shift_bits(ref_s, 40, rb);
    #1 check("R2 done reload", cfg_done_o, 1);

    // R8: minterm lists
    for (int v = 0; v < 8; v++) begin
      logic [2:0] e;
      @(negedge clk_i);
      in_i = 3'(v);
      e[2] = (v >= 1 && v <= 4);
      e[1] = (v == 2 || v == 6 || v == 7);
      e[0] = (v == 4 || v == 6 || v == 7);
      #1 check("R8 ref function", out_o, e);
    end

    // R10: hold with en low while data toggles
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      cfg_data_i = i[0];
    end
    #1 check("R10 hold done", cfg_done_o, 1);
    sweep(ref_s, "R10 hold pattern");

    // config B: R5 conflict, R6 empty/disabled, R7 empty output
    b_s = '0;
    b_s[24] = 1;                                // t0 enabled, no literals -> 1
    set_lit(b_s, 1, 2, 0); set_lit(b_s, 1, 2, 1); b_s[25] = 1;  // t1 conflict -> 0
    set_lit(b_s, 2, 0, 0);                      // t2 disabled -> 0
    set_lit(b_s, 3, 1, 1); b_s[27] = 1;         // t3 = y'
    b_s[28+0] = 1;                              // out0 = t0
    b_s[32+1] = 1; b_s[32+2] = 1;               // out1 = t1|t2
    b_s[36+3] = 1;                              // out2 = t3
    @(negedge clk_i);
    in_i = 3'd7;
    @(negedge clk_i);
    cfg_en_i = 1'b1; cfg_data_i = b_s[0];
    @(posedge clk_i);
    #1 check("R10 done clears", cfg_done_o, 0);
    check("R3 out gated reload", out_o, 0);
    @(negedge clk_i); cfg_en_i = 1'b0;
    // finish the rest of B, capturing the remaining readback
    rb = '0;
    for (int p = 1; p < W; p++) begin
      @(negedge clk_i);
      cfg_en_i = 1'b1; cfg_data_i = b_s[p];
      #1 rb[p] = cfg_dout_o;
      @(posedge clk_i);
    end
    @(negedge clk_i); cfg_en_i = 1'b0;
    check("R9 readback tail", rb[W-1:1], ref_s[W-1:1]);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk_i);
      in_i = 3'(v);
      #1 check("R5 R6 R7 config B", out_o, {~in_i[1], 1'b0, 1'b1});
    end

    // pseudo-random patterns, R4 layout via model, R9 readback
    cur_s = b_s;
    lfsr = 16'hace1;
    for (int n = 0; n < 6; n++) begin
      stream_t s;
      for (int p = 0; p < W; p++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        s[p] = lfsr[0];
      end
      shift_bits(s, W, rb);
      check("R9 readback", rb, cur_s);
      #1 check("R2 done", cfg_done_o, 1);
      sweep(s, "R4 R5 R7 pattern");
      cur_s = s;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule